// File: doc/BRIEF.md
# Burst Frame-Buffer Reader

This block fetches a display frame held in shared memory and streams it, word by word, to a pixel consumer. It is the memory-side half of a display controller. A memory-mapped master port issues burst reads and takes the returned beats. The beats are written into an on-chip synchronous FIFO. The display timing logic drains that FIFO one pixel at a time. Each pixel takes one data word, so the byte address steps by four for every word.

The block is restarted once per frame by a start-of-frame pulse taken from the display's vertical sync. When it restarts, it takes the current frame base address and the frame length in pixels, for example 240×320 = 76800. It then works through the buffer in bursts of a fixed length. The final burst is trimmed to the words that remain. A burst is issued only when the FIFO can take all of its beats. At most one burst is in flight at a time. A start pulse that arrives while a burst is in flight is remembered and takes effect once that burst has fully returned.

Top module: `fbr_burst_reader`

## Requirements
- R1: While reset is asserted, and right after it is released, `mm_read` is low and `pix_avail` is low. No read is issued until a start-of-frame pulse arrives.
- R2: After a `frame_start` pulse, the first burst of the frame is presented at `base_addr`, as sampled when the restart takes effect.
- R3: While `mm_read` is high and `mm_waitrequest` is high, `mm_read` stays high and `mm_address` and `mm_burstcount` do not change. The request is accepted on the first edge where `mm_waitrequest` is low.
- R4: Every burst has `mm_burstcount` = BURST_LEN, except the last burst of the frame, which carries the remainder (1 to BURST_LEN). The sum over a frame equals `frame_pixels`. A length of zero issues no burst.
- R5: A burst is requested only when the FIFO has at least BURST_LEN free entries. With the consumer stalled and the default sizes, exactly FIFO_DEPTH/BURST_LEN bursts are issued. A further burst follows only after BURST_LEN words have been drained.
- R6: Only one burst is outstanding at a time. Each burst starts at the previous burst's address plus 4 × its burstcount.
- R7: Returned words reach `pix_data` in order, with none lost or duplicated, and the FIFO never overflows.
- R8: `pix_avail` is high whenever the FIFO holds at least one word. `pix_data` shows the oldest word, and `pix_rd` removes it on the clock edge. A `pix_rd` while `pix_avail` is low has no effect.
- R9: A `frame_start` pulse that arrives while a burst is outstanding does not cut that burst short. The next burst begins at the newly sampled `base_addr`, and the new frame's length applies.
- R10: `mm_byteenable` is all ones on every read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | One-cycle start-of-frame pulse (from vertical sync) |
| base_addr | input | ADDR_W | Byte address of the first pixel of the frame |
| frame_pixels | input | LEN_W | Frame length in pixels (one data word each) |
| mm_address | output | ADDR_W | Burst start byte address |
| mm_read | output | 1 | Read request, held until accepted |
| mm_burstcount | output | BC_W | Beats in the requested burst |
| mm_byteenable | output | DATA_W/8 | Byte enables, all ones |
| mm_waitrequest | input | 1 | Slave stall; the request is accepted when low |
| mm_readdata | input | DATA_W | Returned read beat |
| mm_readdatavalid | input | 1 | Qualifies `mm_readdata` |
| pix_rd | input | 1 | Consumer pops one pixel |
| pix_data | output | DATA_W | Oldest pixel in the FIFO |
| pix_avail | output | 1 | At least one pixel is held |

## Verification
The assertions assume the memory side behaves like a well-formed slave. Read beats arrive only after a burst has been accepted, there are never more beats than its burstcount, and no beat arrives in the same cycle as the acceptance. Under those assumptions, the outstanding-beat counter and the overflow check are meaningful. The bench's memory model enforces the assumptions by construction. It starts returning beats at least two cycles after acceptance, stops after exactly burstcount beats, and inserts stall and gap cycles only on top of that. The start-of-frame pulse is always exactly one cycle wide, and a frame length is never changed except together with a pulse.

// File: rtl/fbr_pkg.sv
`timescale 1ns/1ps
package fbr_pkg;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_DATA = 2'd2
   } fbr_state_e;

   function automatic bit fbr_is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/fbr_sync_fifo.sv
`timescale 1ns/1ps
module fbr_sync_fifo #(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic                         rd_en,
   output logic [DATA_W-1:0]            rd_data,
   output logic                         empty,
   output logic                         full,
   output logic [$clog2(DEPTH+1)-1:0]   free_cnt
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [DATA_W-1:0] store [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CNT_W-1:0]  fill;
   logic              wr_ok, rd_ok;

   assign empty    = (fill == '0);
   assign full     = (fill == CNT_W'(DEPTH));
   assign free_cnt = CNT_W'(DEPTH) - fill;
   assign wr_ok    = wr_en && !full;
   assign rd_ok    = rd_en && !empty;
   assign rd_data  = store[rd_ptr];

   generate
      if (fbr_pkg::fbr_is_pow2(DEPTH)) begin : g_wrap_natural
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_compare
         assign wr_nxt = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (wr_ok) store[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         fill   <= '0;
      end else begin
         if (wr_ok) wr_ptr <= wr_nxt;
         if (rd_ok) rd_ptr <= rd_nxt;
         case ({wr_ok, rd_ok})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/fbr_addr_gen.sv
`timescale 1ns/1ps
module fbr_addr_gen #(
   parameter int ADDR_W         = 32,
   parameter int LEN_W          = 17,
   parameter int BURST_LEN      = 8,
   parameter int BYTES_PER_BEAT = 4,
   parameter int BC_W           = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [LEN_W-1:0]  load_len,
   input  logic              advance,
   input  logic [BC_W-1:0]   adv_beats,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              has_work,
   output logic [BC_W-1:0]   next_beats
);
   logic [LEN_W-1:0]  remain;
   logic [ADDR_W-1:0] step_bytes;

   generate
      if (fbr_pkg::fbr_is_pow2(BYTES_PER_BEAT)) begin : g_step_shift
         assign step_bytes = ADDR_W'(adv_beats) << $clog2(BYTES_PER_BEAT);
      end else begin : g_step_mult
         assign step_bytes = ADDR_W'(adv_beats) * ADDR_W'(BYTES_PER_BEAT);
      end
   endgenerate

   assign has_work   = (remain != '0);
   assign next_beats = (remain >= LEN_W'(BURST_LEN)) ? BC_W'(BURST_LEN)
                                                    : remain[BC_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         remain   <= '0;
      end else if (load) begin
         cur_addr <= load_addr;
         remain   <= load_len;
      end else if (advance) begin
         cur_addr <= cur_addr + step_bytes;
         remain   <= remain - LEN_W'(adv_beats);
      end
   end
endmodule

// File: rtl/fbr_burst_fsm.sv
`timescale 1ns/1ps
module fbr_burst_fsm #(
   parameter int BURST_LEN = 8,
   parameter int BC_W      = 4,
   parameter int CNT_W     = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sof,
   input  logic             has_work,
   input  logic [BC_W-1:0]  next_beats,
   input  logic [CNT_W-1:0] fifo_free,
   input  logic             waitreq,
   input  logic             rdvalid,
   output logic             load,
   output logic             accept,
   output logic             rd_req,
   output logic [BC_W-1:0]  beats,
   output logic             push
);
   import fbr_pkg::*;

   fbr_state_e       state;
   logic             sof_pend;
   logic [BC_W-1:0]  left;
   logic             room, issue, last_beat;

   assign room      = (fifo_free >= CNT_W'(BURST_LEN));
   assign load      = (state == FS_IDLE) && sof_pend;
   assign issue     = (state == FS_IDLE) && !sof_pend && has_work && room;
   assign rd_req    = (state == FS_REQ);
   assign accept    = rd_req && !waitreq;
   assign push      = (state == FS_DATA) && rdvalid;
   assign last_beat = push && (left == BC_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) sof_pend <= 1'b0;
      else        sof_pend <= (sof_pend && !load) || sof;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= FS_IDLE;
         beats <= '0;
         left  <= '0;
      end else begin
         case (state)
            FS_IDLE: if (issue) begin
               state <= FS_REQ;
               beats <= next_beats;
            end
            FS_REQ: if (accept) begin
               state <= FS_DATA;
               left  <= beats;
            end
            FS_DATA: if (push) begin
               left <= left - 1'b1;
               if (last_beat) state <= FS_IDLE;
            end
            default: state <= FS_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/fbr_burst_reader.sv
`timescale 1ns/1ps
module fbr_burst_reader #(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LEN_W      = 17,
   parameter int BURST_LEN  = 8,
   parameter int FIFO_DEPTH = 32,
   localparam int BC_W      = $clog2(BURST_LEN + 1),
   localparam int BE_W      = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic [LEN_W-1:0]  frame_pixels,
   output logic [ADDR_W-1:0] mm_address,
   output logic              mm_read,
   output logic [BC_W-1:0]   mm_burstcount,
   output logic [BE_W-1:0]   mm_byteenable,
   input  logic              mm_waitrequest,
   input  logic [DATA_W-1:0] mm_readdata,
   input  logic              mm_readdatavalid,
   input  logic              pix_rd,
   output logic [DATA_W-1:0] pix_data,
   output logic              pix_avail
);
   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   generate
      if (BURST_LEN < 1 || BURST_LEN > FIFO_DEPTH) begin : g_bad_burst
         $error("BURST_LEN must lie in 1..FIFO_DEPTH");
      end
      if (DATA_W % 8 != 0) begin : g_bad_data
         $error("DATA_W must be a whole number of bytes");
      end
      if (LEN_W < BC_W) begin : g_bad_len
         $error("LEN_W too narrow for a burst count");
      end
   endgenerate

   logic             load, accept, push, has_work, fifo_empty, fifo_full;
   logic [BC_W-1:0]  next_beats, beats;
   logic [CNT_W-1:0] fifo_free;

   fbr_addr_gen #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_LEN(BURST_LEN),
      .BYTES_PER_BEAT(BE_W), .BC_W(BC_W)
   ) u_addr (
      .clk(clk), .rst_n(rst_n),
      .load(load), .load_addr(base_addr), .load_len(frame_pixels),
      .advance(accept), .adv_beats(beats),
      .cur_addr(mm_address), .has_work(has_work), .next_beats(next_beats)
   );

   fbr_burst_fsm #(
      .BURST_LEN(BURST_LEN), .BC_W(BC_W), .CNT_W(CNT_W)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n),
      .sof(frame_start), .has_work(has_work), .next_beats(next_beats),
      .fifo_free(fifo_free), .waitreq(mm_waitrequest), .rdvalid(mm_readdatavalid),
      .load(load), .accept(accept), .rd_req(mm_read), .beats(beats), .push(push)
   );

   fbr_sync_fifo #(
      .DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)
   ) u_fifo (
      .clk(clk), .rst_n(rst_n),
      .wr_en(push), .wr_data(mm_readdata),
      .rd_en(pix_rd), .rd_data(pix_data),
      .empty(fifo_empty), .full(fifo_full), .free_cnt(fifo_free)
   );

   assign mm_burstcount = beats;
   assign mm_byteenable = '1;
   assign pix_avail     = !fifo_empty;
endmodule

// File: rtl/fbr_checker.sv
`timescale 1ns/1ps
module fbr_checker #(
   parameter int ADDR_W    = 32,
   parameter int BURST_LEN = 8,
   parameter int BC_W      = 4,
   parameter int CNT_W     = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mm_read,
   input logic              mm_waitrequest,
   input logic [ADDR_W-1:0] mm_address,
   input logic [BC_W-1:0]   mm_burstcount,
   input logic              mm_readdatavalid,
   input logic              pix_avail,
   input logic              pix_rd,
   input logic [CNT_W-1:0]  fifo_free
);
   logic [BC_W:0] outst;

   always_ff @(posedge clk) begin
      if (!rst_n) outst <= '0;
      else if (mm_read && !mm_waitrequest) outst <= outst + (BC_W+1)'(mm_burstcount);
      else if (mm_readdatavalid && outst != '0) outst <= outst - 1'b1;
   end

   p_hold_while_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mm_read && mm_waitrequest |=> mm_read && $stable(mm_address) && $stable(mm_burstcount));

   p_burst_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
      mm_read |-> (mm_burstcount != '0) && (mm_burstcount <= BC_W'(BURST_LEN)));

   p_room_at_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mm_read) |-> fifo_free >= CNT_W'(BURST_LEN));

   p_single_outstanding_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mm_read |-> outst == '0);

   p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mm_readdatavalid |-> fifo_free != '0);

   p_avail_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      pix_avail && !pix_rd |=> pix_avail);
endmodule

bind fbr_burst_reader fbr_checker #(
   .ADDR_W(ADDR_W), .BURST_LEN(BURST_LEN), .BC_W(BC_W), .CNT_W(CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .mm_read(mm_read), .mm_waitrequest(mm_waitrequest),
   .mm_address(mm_address), .mm_burstcount(mm_burstcount),
   .mm_readdatavalid(mm_readdatavalid),
   .pix_avail(pix_avail), .pix_rd(pix_rd), .fifo_free(fifo_free)
);

// File: tb/tb_fbr_burst_reader.sv
`timescale 1ns/1ps
module tb_fbr_burst_reader;
   localparam int B    = 8;
   localparam int BC_W = $clog2(B + 1);
   localparam int NVEC = 6;
   // {base[63:32], length[31:16], stall cycles[15:8], gap flag[7:0]}
   localparam logic [63:0] VEC [NVEC] = '{
      {32'h0000_1000, 16'd64, 8'd0, 8'd0},
      {32'h0000_2000, 16'd20, 8'd2, 8'd1},
      {32'h0001_0000, 16'd8,  8'd1, 8'd0},
      {32'h0000_3000, 16'd3,  8'd3, 8'd1},
      {32'h0000_4000, 16'd1,  8'd0, 8'd1},
      {32'h0000_5000, 16'd0,  8'd0, 8'd0}
   };

   logic clk = 0, rst_n = 0, frame_start = 0;
   logic [31:0] base_addr = '0;
   logic [16:0] frame_pixels = '0;
   logic [31:0] mm_address, mm_readdata = '0, pix_data;
   logic mm_read, mm_waitrequest = 1, mm_readdatavalid = 0, pix_rd = 0, pix_avail;
   logic [BC_W-1:0] mm_burstcount;
   logic [3:0] mm_byteenable;

   fbr_burst_reader dut (.*);

   always #5 clk = ~clk;

   int n_chk = 0, n_fail = 0;
   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] pat(input logic [31:0] a);
      return a ^ 32'h5AC3_0F0F;
   endfunction

   // memory model and pixel consumer, driven on the falling edge
   int wmode = 0, gapm = 0, wcnt = 0, pend = 0, lat = 0, budget = -1, got = 0, log_n = 0;
   bit gapt = 0, chk_data = 1, hold_chk = 0;
   logic [31:0] raddr = '0, exp_addr = '0, prev_a = '0;
   logic [BC_W-1:0] prev_b = '0;
   logic [31:0] log_addr [64];
   int log_bc [64];

   always @(negedge clk) begin
      if (!rst_n) begin
         mm_waitrequest = 1; mm_readdatavalid = 0; pix_rd = 0;
         pend = 0; wcnt = 0; hold_chk = 0;
      end else begin
         bit acc_now;
         acc_now = 0;
         if (hold_chk) begin
            check(mm_read === 1'b1, "R3 read held", 32'(mm_read), 1);
            check(mm_address === prev_a && mm_burstcount === prev_b,
                  "R3 addr/count held", mm_address, prev_a);
         end
         if (mm_read && pend == 0) begin
            if (wcnt < wmode) begin
               mm_waitrequest = 1; wcnt++;
            end else begin
               mm_waitrequest = 0; wcnt = 0; acc_now = 1;
               check(mm_byteenable === 4'hF, "R10 byteenable", 32'(mm_byteenable), 32'hF);
               if (log_n < 64) begin
                  log_addr[log_n] = mm_address; log_bc[log_n] = int'(mm_burstcount);
               end
               log_n++;
               pend = int'(mm_burstcount); raddr = mm_address; lat = 2; gapt = 0;
            end
         end else begin
            if (mm_read) check(0, "R6 request while beats outstanding", 1, 0);
            mm_waitrequest = 1;
         end
         hold_chk = mm_read && mm_waitrequest;
         prev_a = mm_address; prev_b = mm_burstcount;
         mm_readdatavalid = 0;
         if (pend > 0 && !acc_now) begin
            if (lat > 0) lat--;
            else if (gapm != 0 && gapt) gapt = 0;
            else begin
               mm_readdatavalid = 1; mm_readdata = pat(raddr);
               raddr += 4; pend--; gapt = 1;
            end
         end
         pix_rd = 0;
         if (pix_avail && budget != 0) begin
            if (chk_data) check(pix_data === pat(exp_addr), "R7 pixel order/data", pix_data, pat(exp_addr));
            exp_addr += 4; got++; pix_rd = 1;
            if (budget > 0) budget--;
         end
      end
   end

   task automatic pulse_sof(input logic [31:0] b, input int len);
      base_addr = b; frame_pixels = 17'(len); frame_start = 1;
      @(negedge clk);
      frame_start = 0;
   endtask

   task automatic run_frame(input logic [31:0] b, input int len, input int wm, input int gp);
      int nb;
      @(negedge clk);
      wmode = wm; gapm = gp; exp_addr = b; got = 0; log_n = 0; budget = -1; chk_data = 1;
      pulse_sof(b, len);
      for (int c = 0; c < 5000 && got < len; c++) @(negedge clk);
      repeat (20) @(negedge clk);
      nb = (len + B - 1) / B;
      check(log_n == nb, "R4 bursts per frame", log_n, nb);
      for (int i = 0; i < nb && i < 64; i++) begin
         int e;
         e = (len - i * B >= B) ? B : len - i * B;
         if (i == 0) check(log_addr[i] == b, "R2 first burst at base", log_addr[i], b);
         else        check(log_addr[i] == b + 32'(i * B * 4), "R6 address step", log_addr[i], b + 32'(i * B * 4));
         check(log_bc[i] == e, "R4 burstcount", log_bc[i], e);
      end
      check(got == len, "R7 words delivered", got, len);
      check(pix_avail === 1'b0, "R8 drained", 32'(pix_avail), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(mm_read === 1'b0, "R1 read low in reset", 32'(mm_read), 0);
      check(pix_avail === 1'b0, "R1 avail low in reset", 32'(pix_avail), 0);
      rst_n = 1;
      repeat (10) @(negedge clk);
      check(mm_read === 1'b0 && log_n == 0, "R1 idle before first frame", log_n, 0);

      for (int v = 0; v < NVEC; v++)
         run_frame(VEC[v][63:32], int'(VEC[v][31:16]), int'(VEC[v][15:8]), int'(VEC[v][7:0]));

      // R5: stalled consumer, refill only after a whole burst of space frees up
      wmode = 1; gapm = 0; exp_addr = 32'h0002_0000; got = 0; log_n = 0; budget = 0; chk_data = 1;
      pulse_sof(32'h0002_0000, 100);
      repeat (300) @(negedge clk);
      check(log_n == 4, "R5 bursts with consumer stalled", log_n, 4);
      check(pix_avail === 1'b1, "R8 avail while holding data", 32'(pix_avail), 1);
      budget = 7;
      repeat (100) @(negedge clk);
      check(log_n == 4, "R5 no burst with 7 free", log_n, 4);
      check(got == 7, "R8 pops honoured", got, 7);
      budget = 1;
      repeat (100) @(negedge clk);
      check(log_n == 5, "R5 burst after 8 free", log_n, 5);
      budget = -1;
      for (int c = 0; c < 5000 && got < 100; c++) @(negedge clk);
      repeat (20) @(negedge clk);
      check(log_n == 13, "R4 bursts for 100 words", log_n, 13);
      check(log_bc[12] == 4, "R4 trimmed last burst", log_bc[12], 4);
      check(got == 100, "R7 all words after stall", got, 100);

      // R8: pop on empty FIFO has no effect
      budget = -1;
      @(negedge clk);
      check(pix_avail === 1'b0, "R8 empty before pop", 32'(pix_avail), 0);
      force_pop();

      // R9: restart while a burst is in flight
      wmode = 0; gapm = 1; got = 0; log_n = 0; chk_data = 0; exp_addr = 32'h1000;
      pulse_sof(32'h0000_1000, 64);
      for (int c = 0; c < 200 && log_n < 1; c++) @(negedge clk);
      pulse_sof(32'h0000_8000, 40);
      for (int c = 0; c < 5000 && got < 48; c++) @(negedge clk);
      repeat (30) @(negedge clk);
      check(log_bc[0] == 8, "R9 in-flight burst completes", log_bc[0], 8);
      check(log_addr[1] == 32'h8000, "R9 next burst at new base", log_addr[1], 32'h8000);
      check(log_n == 6, "R9 new frame length applied", log_n, 6);
      check(got == 48, "R9 words total", got, 48);

      // R1: reset in the middle of a frame
      got = 0; log_n = 0;
      pulse_sof(32'h0000_9000, 64);
      for (int c = 0; c < 500 && log_n < 2; c++) @(negedge clk);
      rst_n = 0;
      repeat (2) @(negedge clk);
      check(mm_read === 1'b0, "R1 read low after mid-frame reset", 32'(mm_read), 0);
      check(pix_avail === 1'b0, "R1 avail low after mid-frame reset", 32'(pix_avail), 0);
      rst_n = 1;
      repeat (20) @(negedge clk);
      check(mm_read === 1'b0, "R1 no read without new frame", 32'(mm_read), 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   // R8: hold pix_rd for a cycle with nothing stored, then confirm nothing appears
   task automatic force_pop();
      budget = 0;
      @(negedge clk);
      pix_rd = 1;
      @(negedge clk);
      pix_rd = 0;
      check(pix_avail === 1'b0, "R8 pop on empty ignored", 32'(pix_avail), 0);
      check(mm_read === 1'b0, "R8 no fetch after empty pop", 32'(mm_read), 0);
      budget = -1;
   endtask
endmodule